// File: doc/BRIEF.md
# Shared Memory Bus Priority Arbiter

This block shares one data-memory bus between three masters: a processor core (master 0), the read channel of a DMA engine (master 1) and its write channel (master 2). Each master raises a request together with a burst flag, a write flag, a target select, an address and write data. A burst ends with a last-beat flag. When the bus is idle, the arbiter picks one winner. It locks the grant to that master until the transfer ends. It then leaves one idle cycle before it arbitrates again.

Priority depends on the state of each transaction, not on a fixed ranking of masters. The master that holds the bus keeps it against every newcomer. Among the new requests, a burst outranks a single access. At equal rank the processor wins. When both DMA channels tie, a pointer alternates between them.

The arbiter also sets the wait states of each beat from the target select and the direction. It strobes ready to the owner when a beat completes. For reads it strobes read-valid as well, and the read data is taken straight from the bus.

Top module: `bus_prio_arb`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, no grant, ready or read-valid is asserted and the bus is inactive. Reset leaves the DMA alternation pointer favouring master 1.
- R2: At most one grant bit is high. A request seen in an idle cycle yields the grant in the next cycle. While granted, the bus carries the owner's address, write data, write flag and target.
- R3: In an arbitration cycle, a burst request (burst flag high) beats any single request, whatever the master index.
- R4: When the requests that share the top rank include master 0, master 0 is granted.
- R5: When masters 1 and 2 tie at the top rank without master 0, the pointer decides the winner. The pointer changes only in an arbitration cycle where both masters 1 and 2 request and one of them wins. It then favours the one that lost. A cycle won by master 0 leaves it unchanged.
- R6: The grant stays fixed, and every other request is ignored, until the transfer ends. A single access ends at its ready. A burst ends at the ready of the beat whose last flag is high.
- R7: The cycle after a transfer ends carries no grant. Arbitration takes place in that cycle.
- R8: Target code 0 (I/O) and code 3 (treated as I/O) complete every beat, read or write, in the first cycle it is counted from.
- R9: Target code 1 (SRAM): a write beat takes 1 cycle. A single read or the first read beat takes 2 cycles. Each later burst read beat takes 1 cycle.
- R10: Target code 2 (EEPROM): a write beat takes 1 cycle. A single read or the first read beat takes 3 cycles. Each later burst read beat takes 2 cycles. For every target, a first beat is counted from the first grant cycle as cycle 1, and a later beat is counted from the cycle after the previous ready.
- R11: Read-valid goes to the owner together with ready, and only for reads. The read data output equals the bus read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mReq | input | 3 | Request, one bit per master |
| mBurst | input | 3 | Burst flag per master |
| mLast | input | 3 | Last-beat flag per master |
| mWe | input | 3 | Write flag per master |
| mTgt | input | 6 | Target select, 2 bits per master |
| mAddr | input | 3*ADDR_W | Address per master |
| mWdata | input | 3*DATA_W | Write data per master |
| mGrant | output | 3 | One-hot grant |
| mReady | output | 3 | Beat-complete strobe to the owner |
| mRvalid | output | 3 | Read-data-valid strobe to the owner |
| mRdata | output | DATA_W | Read data |
| busActive | output | 1 | Bus owned this cycle |
| busWe | output | 1 | Owner's write flag |
| busTgt | output | 2 | Owner's target select |
| busAddr | output | ADDR_W | Owner's address |
| busWdata | output | DATA_W | Owner's write data |
| busRdata | input | DATA_W | Read data returned from the target |

## Verification
The bench builds the arbiter with 8-bit address and data. The latency parameters keep their defaults: 2 and 3 cycles for SRAM and EEPROM reads, and gaps of 1 and 2 cycles between burst read beats. With 8-bit fields a stub target can return the address XOR 0x5A, so each read beat's data can be predicted exactly. The default latencies are short enough to step through every beat of a four-beat SRAM burst and a three-beat EEPROM burst, and through a lock held while a rival waits.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int NUM_M = 3;
  localparam int OWN_W = 2;

  typedef enum logic [1:0] {
    TGT_IO   = 2'd0,
    TGT_SRAM = 2'd1,
    TGT_EE   = 2'd2,
    TGT_RSV  = 2'd3
  } tgt_e;

  typedef struct packed {
    logic             active;
    logic [OWN_W-1:0] owner;
    logic             beatDone;
    logic             xferDone;
  } arb_strobe_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import bus_arb_pkg::*;
#(
  parameter int SRAM_RD_LAT = 2,
  parameter int EE_RD_LAT   = 3,
  parameter int SRAM_GAP    = 1,
  parameter int EE_GAP      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_M-1:0]  req,
  input  logic [NUM_M-1:0]  burst,
  input  logic [NUM_M-1:0]  last,
  input  logic [NUM_M-1:0]  we,
  input  logic [2*NUM_M-1:0] tgt,
  output arb_strobe_t       strb,
  output logic [NUM_M-1:0]  grantOut
);
  localparam int MAX_A   = (SRAM_RD_LAT > EE_RD_LAT) ? SRAM_RD_LAT : EE_RD_LAT;
  localparam int MAX_B   = (SRAM_GAP > EE_GAP) ? SRAM_GAP : EE_GAP;
  localparam int MAX_LAT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic             active, isBurst, altPtr;
  logic [OWN_W-1:0] owner, win;
  logic [CNT_W-1:0] waitCnt;
  logic [NUM_M-1:0] cand;
  logic             beatDone, xferDone;

  function automatic logic [CNT_W-1:0] latOf(input logic [1:0] t, input logic w,
                                             input logic first);
    logic [CNT_W-1:0] v;
    v = '0;
    if (!w) begin
      if (t == TGT_SRAM)    v = first ? CNT_W'(SRAM_RD_LAT - 1) : CNT_W'(SRAM_GAP - 1);
      else if (t == TGT_EE) v = first ? CNT_W'(EE_RD_LAT - 1)   : CNT_W'(EE_GAP - 1);
    end
    return v;
  endfunction

  // rank: burst requests first, then singles; master 0 wins ties; pointer splits DMA ties
  always_comb begin
    cand = (|(req & burst)) ? (req & burst) : req;
    if (cand[0])                win = 2'd0;
    else if (cand[1] && cand[2]) win = altPtr ? 2'd2 : 2'd1;
    else if (cand[1])           win = 2'd1;
    else                        win = 2'd2;
  end

  assign beatDone = active && (waitCnt == '0);
  assign xferDone = beatDone && (!isBurst || last[owner]);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      owner   <= '0;
      isBurst <= 1'b0;
      waitCnt <= '0;
      altPtr  <= 1'b0;
    end else if (!active) begin
      if (|req) begin
        active  <= 1'b1;
        owner   <= win;
        isBurst <= burst[win];
        waitCnt <= latOf(tgt[2*win +: 2], we[win], 1'b1);
        if (req[1] && req[2] && win != 2'd0) altPtr <= (win == 2'd1);
      end
    end else if (beatDone) begin
      if (xferDone) active <= 1'b0;
      else          waitCnt <= latOf(tgt[2*owner +: 2], we[owner], 1'b0);
    end else begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign grantOut = active ? (NUM_M'(1) << owner) : '0;

  always_comb begin
    strb.active   = active;
    strb.owner    = owner;
    strb.beatDone = beatDone;
    strb.xferDone = xferDone;
  end

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (grantOut == '0 && !altPtr));
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(grantOut));
  a_r6_lock: assert property (@(posedge clk) disable iff (rst)
    (active && !xferDone) |=> (grantOut == $past(grantOut)));
  a_r7_gap: assert property (@(posedge clk) disable iff (rst) xferDone |=> (grantOut == '0));
  a_r4_cpu_first: assert property (@(posedge clk) disable iff (rst)
    (!active && req[0] && (burst[0] || !(|(req & burst)))) |=> grantOut[0]);
  a_r5_ptr_rd: assert property (@(posedge clk) disable iff (rst)
    (!active && req[1] && req[2] && win == 2'd1) |=> altPtr);
  a_r5_ptr_wr: assert property (@(posedge clk) disable iff (rst)
    (!active && req[1] && req[2] && win == 2'd2) |=> !altPtr);
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import bus_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  arb_strobe_t             strb,
  input  logic [NUM_M-1:0]        mWe,
  input  logic [2*NUM_M-1:0]      mTgt,
  input  logic [NUM_M*ADDR_W-1:0] mAddr,
  input  logic [NUM_M*DATA_W-1:0] mWdata,
  input  logic [DATA_W-1:0]       busRdata,
  output logic                    busActive,
  output logic                    busWe,
  output logic [1:0]              busTgt,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [DATA_W-1:0]       busWdata,
  output logic [NUM_M-1:0]        mReady,
  output logic [NUM_M-1:0]        mRvalid,
  output logic [DATA_W-1:0]       mRdata
);
  assign busActive = strb.active;
  assign busWe     = mWe[strb.owner];
  assign busTgt    = mTgt[2*strb.owner +: 2];
  assign busAddr   = mAddr[ADDR_W*strb.owner +: ADDR_W];
  assign busWdata  = mWdata[DATA_W*strb.owner +: DATA_W];
  assign mRdata    = busRdata;

  for (genvar g = 0; g < NUM_M; g++) begin : g_route
    assign mReady[g]  = strb.beatDone && (strb.owner == OWN_W'(g));
    assign mRvalid[g] = mReady[g] && !mWe[g];
  end

  a_r11_rvalid_read: assert property (@(posedge clk) disable iff (rst)
    (|mRvalid) |-> (!busWe && busActive));
  a_r2_ready_on_bus: assert property (@(posedge clk) disable iff (rst)
    (|mReady) |-> busActive);
  a_r6_end_on_beat: assert property (@(posedge clk) disable iff (rst)
    strb.xferDone |-> (|mReady));
endmodule

// File: rtl/bus_prio_arb.sv
module bus_prio_arb
  import bus_arb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SRAM_RD_LAT = 2,
  parameter int EE_RD_LAT   = 3,
  parameter int SRAM_GAP    = 1,
  parameter int EE_GAP      = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2:0]              mReq,
  input  logic [2:0]              mBurst,
  input  logic [2:0]              mLast,
  input  logic [2:0]              mWe,
  input  logic [5:0]              mTgt,
  input  logic [3*ADDR_W-1:0]     mAddr,
  input  logic [3*DATA_W-1:0]     mWdata,
  output logic [2:0]              mGrant,
  output logic [2:0]              mReady,
  output logic [2:0]              mRvalid,
  output logic [DATA_W-1:0]       mRdata,
  output logic                    busActive,
  output logic                    busWe,
  output logic [1:0]              busTgt,
  output logic [ADDR_W-1:0]       busAddr,
  output logic [DATA_W-1:0]       busWdata,
  input  logic [DATA_W-1:0]       busRdata
);
  arb_strobe_t strb;

  arb_ctrl #(
    .SRAM_RD_LAT(SRAM_RD_LAT), .EE_RD_LAT(EE_RD_LAT),
    .SRAM_GAP(SRAM_GAP), .EE_GAP(EE_GAP)
  ) i_ctrl (
    .clk(clk), .rst(rst), .req(mReq), .burst(mBurst), .last(mLast),
    .we(mWe), .tgt(mTgt), .strb(strb), .grantOut(mGrant)
  );

  arb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .mWe(mWe), .mTgt(mTgt),
    .mAddr(mAddr), .mWdata(mWdata), .busRdata(busRdata),
    .busActive(busActive), .busWe(busWe), .busTgt(busTgt),
    .busAddr(busAddr), .busWdata(busWdata),
    .mReady(mReady), .mRvalid(mRvalid), .mRdata(mRdata)
  );
endmodule

// File: tb/test_bus_prio_arb.sv
`timescale 1ns/1ps
module test_bus_prio_arb;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] req = '0, bst = '0, lst = '0, we = '0;
  logic [5:0] tgt = '0;
  logic [3*AW-1:0] addr = '0;
  logic [3*DW-1:0] wdata = '0;
  logic [2:0] grant, ready, rvalid;
  logic [DW-1:0] rdata, busWdata, busRdata;
  logic [AW-1:0] busAddr;
  logic busActive, busWe;
  logic [1:0] busTgt;
  int nChk = 0, nBad = 0;

  always #2 clk = ~clk;
  assign busRdata = busAddr ^ 8'h5A;

  bus_prio_arb #(.ADDR_W(AW), .DATA_W(DW)) i_bus_prio_arb (
    .clk(clk), .rst(rst), .mReq(req), .mBurst(bst), .mLast(lst), .mWe(we),
    .mTgt(tgt), .mAddr(addr), .mWdata(wdata), .mGrant(grant), .mReady(ready),
    .mRvalid(rvalid), .mRdata(rdata), .busActive(busActive), .busWe(busWe),
    .busTgt(busTgt), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  task automatic setM(input int m, input bit r, input bit b, input bit w,
                      input logic [1:0] t, input logic [7:0] a);
    req[m] = r; bst[m] = b; we[m] = w; lst[m] = 1'b0;
    tgt[2*m +: 2] = t; addr[AW*m +: AW] = a; wdata[DW*m +: DW] = ~a;
  endtask

  // one complete transfer by a lone master, checking every beat's latency
  task automatic xfer(input int m, input logic [1:0] t, input bit w, input int beats,
                      input int lFirst, input int lGap, input string rq);
    logic [7:0] a;
    a = 8'h40 + 8'(m * 16);
    step(); setM(m, 1'b1, beats > 1, w, t, a); lst[m] = (beats == 1);
    smp(); chk(grant == 3'b000, "R7", "arbitration cycle grant", grant, 0);
    step(); smp();
    chk(grant == 3'(1 << m), "R2", "grant", grant, 1 << m);
    chk(busAddr == a && busWe == w && busTgt == t, "R2", "bus mirrors owner", busAddr, a);
    for (int b = 0; b < beats; b++) begin
      int n = 0;
      while (!ready[m] && n < 12) begin
        step(); smp(); n++;
      end
      chk(n + 1 == ((b == 0) ? lFirst : lGap), rq, "beat latency", n + 1,
          (b == 0) ? lFirst : lGap);
      if (!w) chk(rvalid[m] && rdata == (a ^ 8'h5A), "R11", "read data", rdata, a ^ 8'h5A);
      else    chk(rvalid == 3'b000, "R11", "no valid on write", rvalid, 0);
      if (b < beats - 1) begin
        step(); a = a + 8'd1; addr[AW*m +: AW] = a; lst[m] = (b + 1 == beats - 1);
        smp();
      end
    end
    step(); req[m] = 1'b0; bst[m] = 1'b0; lst[m] = 1'b0;
    smp(); chk(grant == 3'b000, "R7", "idle after completion", grant, 0);
  endtask

  task automatic tReset();
    rst = 1'b1;
    repeat (3) step();
    smp(); chk(grant == 0 && ready == 0 && rvalid == 0 && !busActive, "R1",
               "outputs in reset", grant, 0);
    step(); rst = 1'b0;
    smp(); chk(grant == 0 && ready == 0 && !busActive, "R1", "outputs after reset", grant, 0);
  endtask

  task automatic tAlternate();
    logic [2:0] expG;
    step(); setM(1, 1'b1, 1'b0, 1'b0, 2'd0, 8'h11); setM(2, 1'b1, 1'b0, 1'b1, 2'd0, 8'h22);
    smp();
    for (int k = 0; k < 4; k++) begin
      expG = (k % 2 == 0) ? 3'b010 : 3'b100;
      step(); smp(); chk(grant == expG, "R5", "alternating DMA grant", grant, expG);
      step(); if (k == 3) begin req[1] = 1'b0; req[2] = 1'b0; end
      smp(); chk(grant == 3'b000, "R7", "gap between grants", grant, 0);
    end
  endtask

  task automatic tCpuTie();
    step();
    setM(0, 1'b1, 1'b0, 1'b0, 2'd0, 8'h01);
    setM(1, 1'b1, 1'b0, 1'b0, 2'd0, 8'h11);
    setM(2, 1'b1, 1'b0, 1'b1, 2'd0, 8'h22);
    smp();
    step(); smp(); chk(grant == 3'b001, "R4", "master 0 wins tie", grant, 1);
    step(); req[0] = 1'b0;
    smp(); chk(grant == 3'b000, "R7", "gap", grant, 0);
    step(); smp(); chk(grant == 3'b010, "R5", "pointer kept after master 0 win", grant, 2);
    step(); req[1] = 1'b0; req[2] = 1'b0;
    smp(); chk(grant == 3'b000, "R7", "gap", grant, 0);
  endtask

  task automatic tBurstFirst();
    step();
    setM(0, 1'b1, 1'b0, 1'b1, 2'd1, 8'h05);
    setM(2, 1'b1, 1'b1, 1'b1, 2'd0, 8'h60);
    smp();
    step(); smp();
    chk(grant == 3'b100 && ready[2], "R3", "burst beats single", grant, 4);
    step(); lst[2] = 1'b1; addr[AW*2 +: AW] = 8'h61;
    smp(); chk(grant == 3'b100 && ready[2], "R6", "held for last beat", grant, 4);
    step(); req[2] = 1'b0; bst[2] = 1'b0; lst[2] = 1'b0;
    smp(); chk(grant == 3'b000, "R7", "gap", grant, 0);
    step(); smp(); chk(grant == 3'b001 && ready[0], "R3", "single served after", grant, 1);
    step(); req[0] = 1'b0;
    smp(); chk(grant == 3'b000, "R7", "gap", grant, 0);
  endtask

  task automatic tLock();
    step(); setM(1, 1'b1, 1'b1, 1'b0, 2'd2, 8'h70);
    smp();
    step(); smp(); chk(grant == 3'b010, "R2", "burst owner", grant, 2);
    step(); setM(0, 1'b1, 1'b1, 1'b0, 2'd0, 8'h08); lst[0] = 1'b1;
    smp(); chk(grant == 3'b010 && ready == 0, "R6", "rival burst ignored", grant, 2);
    step(); smp();
    chk(grant == 3'b010 && ready[1] && rdata == (8'h70 ^ 8'h5A), "R10", "first EE beat", rdata,
        8'h70 ^ 8'h5A);
    step(); lst[1] = 1'b1; addr[AW*1 +: AW] = 8'h71;
    smp(); chk(grant == 3'b010 && ready == 0, "R6", "lock during gap", grant, 2);
    step(); smp(); chk(grant == 3'b010 && ready[1], "R10", "second EE beat", ready, 2);
    step(); req[1] = 1'b0; bst[1] = 1'b0; lst[1] = 1'b0;
    smp(); chk(grant == 3'b000, "R7", "gap", grant, 0);
    step(); smp(); chk(grant == 3'b001 && rvalid[0], "R6", "waiting master served", grant, 1);
    step(); req[0] = 1'b0; bst[0] = 1'b0; lst[0] = 1'b0;
    smp(); chk(grant == 3'b000, "R7", "gap", grant, 0);
  endtask

  initial begin
    #(4 * 100000);
    nBad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    tReset();
    tAlternate();
    tCpuTie();
    xfer(0, 2'd0, 1'b0, 1, 1, 1, "R8");
    xfer(2, 2'd0, 1'b1, 1, 1, 1, "R8");
    xfer(0, 2'd3, 1'b0, 1, 1, 1, "R8");
    xfer(1, 2'd0, 1'b0, 3, 1, 1, "R8");
    xfer(1, 2'd1, 1'b0, 1, 2, 1, "R9");
    xfer(2, 2'd1, 1'b1, 1, 1, 1, "R9");
    xfer(1, 2'd1, 1'b0, 4, 2, 1, "R9");
    xfer(0, 2'd2, 1'b0, 1, 3, 1, "R10");
    xfer(2, 2'd2, 1'b1, 1, 1, 1, "R10");
    xfer(1, 2'd2, 1'b0, 3, 3, 2, "R10");
    xfer(2, 2'd2, 1'b1, 3, 1, 1, "R10");
    tBurstFirst();
    tLock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule